// File: doc/BRIEF.md
# Dual-Line Serial Converter Readout

This block is the host side of a serial link to an eight-channel, 18-bit simultaneous-sampling converter. The converter returns results on two serial lines at once. After a start request, the receiver waits until the converter reports that its conversion is done. It then pulls chip-select low, drives the serial clock and shifts in both lines in parallel. It hands each completed pair of results to the fabric together with their channel numbers.

Each lane carries four 18-bit results, most significant bit first, so one frame takes 72 serial clocks. Lane A returns channels 0 to 3 and lane B returns channels 4 to 7. The converter raises a first-data marker while the first result is on the lines. The receiver samples that marker with the first bit of every frame and raises a sync-error flag if the marker is missing. The serial clock half-period and the chip-select setup and hold times are counted in system clock cycles, and all of them are parameters.

Top module: `adc_dual_serial_rx`

## Requirements
- R1: While reset is held and in the first cycle after it, `cs_n_o` and `sclk_o` are 1, and `word_valid_o`, `sync_err_o` and `rx_active_o` are 0.
- R2: A `start_i` pulse in idle sets `rx_active_o`. `cs_n_o` falls only on the clock edge at which `conv_busy_i` is sampled low, and it stays high for as long as `conv_busy_i` stays high.
- R3: `sclk_o` is 1 when `cs_n_o` falls. `cs_n_o` is low for exactly CS_SETUP cycles before the first falling edge of `sclk_o`.
- R4: A frame contains exactly 72 falling edges of `sclk_o` (with the default parameters). Every low phase and every high phase lasts SCLK_HALF cycles, and `sclk_o` changes only while `cs_n_o` is low.
- R5: After the last rising edge of `sclk_o`, `cs_n_o` stays low for SCLK_HALF + CS_HOLD cycles and then rises. `sclk_o` is 1 whenever `cs_n_o` is 1.
- R6: Line values are sampled on the system clock edge at which `sclk_o` falls, with the first sample taken as bit 17 (the MSB). One cycle after every 18th sample, `word_valid_o` pulses for one cycle with the two 18-bit words on `word_a_o` and `word_b_o`.
- R7: For the k-th word of a frame (k = 0..3), `chan_a_o` = k and `chan_b_o` = k + 4.
- R8: `sync_err_o` is loaded at the first sample of each frame with the inverse of `first_data_i`. It then holds that value until the first sample of the next frame.
- R9: A `start_i` pulse during an active frame is ignored. The frame delivers exactly four words, and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to read one frame |
| conv_busy_i | input | 1 | Converter busy; a frame starts only once this is low |
| cs_n_o | output | 1 | Chip-select to the converter, active low |
| sclk_o | output | 1 | Serial clock, idles high |
| douta_i | input | 1 | Serial data line A (channels 0-3) |
| doutb_i | input | 1 | Serial data line B (channels 4-7) |
| first_data_i | input | 1 | First-data marker from the converter |
| word_valid_o | output | 1 | One-cycle strobe: a word pair is ready |
| word_a_o | output | 18 | Result from line A |
| chan_a_o | output | 3 | Channel number of `word_a_o` |
| word_b_o | output | 18 | Result from line B |
| chan_b_o | output | 3 | Channel number of `word_b_o` |
| sync_err_o | output | 1 | First-data marker was absent at the start of the last frame |
| rx_active_o | output | 1 | A request is pending or a frame is in progress |

## Verification
The hardest situations to reach are a start request that arrives while the converter is still busy, and a second request that arrives in the middle of a frame. The bench holds the busy input high across the first request and checks that chip-select stays high, then releases it. In a later frame it pulses start again partway through the frame and checks that no extra words or second frame appear. A behavioural converter model advances on every serial clock fall and can suppress its first-data marker. This makes the sync-error flag rise in one frame and clear in the next.

// File: rtl/adc_rx_pkg.sv
package adc_rx_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_ARMED,
    SQ_SETUP,
    SQ_LOW,
    SQ_HIGH,
    SQ_HOLD
  } sq_state_t;
endpackage

// File: rtl/adc_rx_seq.sv
module adc_rx_seq
  import adc_rx_pkg::*;
#(
  parameter int WORD_BITS      = 18,
  parameter int WORDS_PER_LANE = 4,
  parameter int SCLK_HALF      = 2,
  parameter int CS_SETUP       = 2,
  parameter int CS_HOLD        = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic conv_busy_i,
  output logic cs_n_o,
  output logic sclk_o,
  output logic smp_o,
  output logic first_o,
  output logic word_end_o,
  output logic [((WORDS_PER_LANE > 1) ? $clog2(WORDS_PER_LANE) : 1)-1:0] widx_o,
  output logic active_o
);
  localparam int TOTAL = WORD_BITS * WORDS_PER_LANE;
  localparam int CNT_W = $clog2(TOTAL + 1);
  localparam int BIW_W = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1;
  localparam int WI_W  = (WORDS_PER_LANE > 1) ? $clog2(WORDS_PER_LANE) : 1;
  localparam int TMAX  = (CS_SETUP > SCLK_HALF) ?
                         ((CS_SETUP > CS_HOLD) ? CS_SETUP : CS_HOLD) :
                         ((SCLK_HALF > CS_HOLD) ? SCLK_HALF : CS_HOLD);
  localparam int TMR_W = (TMAX > 1) ? $clog2(TMAX + 1) : 1;

  sq_state_t        st;
  logic [TMR_W-1:0] tmr;
  logic [CNT_W-1:0] nsmp;
  logic [BIW_W-1:0] biw;
  logic [WI_W-1:0]  widx;
  logic             done_all;

  assign done_all   = (nsmp == CNT_W'(TOTAL));
  assign smp_o      = (tmr == '0) &&
                      ((st == SQ_SETUP) || ((st == SQ_HIGH) && !done_all));
  assign first_o    = smp_o && (nsmp == '0);
  assign word_end_o = smp_o && (biw == BIW_W'(WORD_BITS - 1));
  assign widx_o     = widx;
  assign active_o   = (st != SQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= SQ_IDLE;
      tmr    <= '0;
      cs_n_o <= 1'b1;
      sclk_o <= 1'b1;
      nsmp   <= '0;
      biw    <= '0;
      widx   <= '0;
    end else begin
      case (st)
        SQ_IDLE: if (start_i) st <= SQ_ARMED;
        SQ_ARMED:
          if (!conv_busy_i) begin
            st     <= SQ_SETUP;
            cs_n_o <= 1'b0;
            tmr    <= TMR_W'(CS_SETUP - 1);
          end
        SQ_SETUP:
          if (tmr == '0) begin
            st     <= SQ_LOW;
            sclk_o <= 1'b0;
            tmr    <= TMR_W'(SCLK_HALF - 1);
          end else tmr <= tmr - 1'b1;
        SQ_LOW:
          if (tmr == '0) begin
            st     <= SQ_HIGH;
            sclk_o <= 1'b1;
            tmr    <= TMR_W'(SCLK_HALF - 1);
          end else tmr <= tmr - 1'b1;
        SQ_HIGH:
          if (tmr == '0) begin
            if (done_all) begin
              st  <= SQ_HOLD;
              tmr <= TMR_W'(CS_HOLD - 1);
            end else begin
              st     <= SQ_LOW;
              sclk_o <= 1'b0;
              tmr    <= TMR_W'(SCLK_HALF - 1);
            end
          end else tmr <= tmr - 1'b1;
        SQ_HOLD:
          if (tmr == '0) begin
            st     <= SQ_IDLE;
            cs_n_o <= 1'b1;
          end else tmr <= tmr - 1'b1;
        default: st <= SQ_IDLE;
      endcase

      if (st == SQ_ARMED) begin
        nsmp <= '0;
        biw  <= '0;
        widx <= '0;
      end else if (smp_o) begin
        nsmp <= nsmp + 1'b1;
        if (biw == BIW_W'(WORD_BITS - 1)) begin
          biw  <= '0;
          widx <= widx + 1'b1;
        end else begin
          biw <= biw + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/adc_rx_lane.sv
module adc_rx_lane #(
  parameter int WORD_BITS = 18
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_i,
  input  logic                 word_end_i,
  input  logic                 din_i,
  output logic [WORD_BITS-1:0] word_o
);
  logic [WORD_BITS-1:0] sh;
  logic [WORD_BITS-1:0] nxt;

  assign nxt = {sh[WORD_BITS-2:0], din_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '0;
      word_o <= '0;
    end else if (smp_i) begin
      sh <= nxt;
      if (word_end_i) word_o <= nxt;
    end
  end
endmodule

// File: rtl/adc_dual_serial_rx.sv
module adc_dual_serial_rx #(
  parameter int WORD_BITS      = 18,
  parameter int WORDS_PER_LANE = 4,
  parameter int SCLK_HALF      = 2,
  parameter int CS_SETUP       = 2,
  parameter int CS_HOLD        = 2,
  localparam int CHAN_W        = $clog2(2 * WORDS_PER_LANE)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic                 conv_busy_i,
  output logic                 cs_n_o,
  output logic                 sclk_o,
  input  logic                 douta_i,
  input  logic                 doutb_i,
  input  logic                 first_data_i,
  output logic                 word_valid_o,
  output logic [WORD_BITS-1:0] word_a_o,
  output logic [CHAN_W-1:0]    chan_a_o,
  output logic [WORD_BITS-1:0] word_b_o,
  output logic [CHAN_W-1:0]    chan_b_o,
  output logic                 sync_err_o,
  output logic                 rx_active_o
);
  localparam int LANES = 2;
  localparam int WI_W  = (WORDS_PER_LANE > 1) ? $clog2(WORDS_PER_LANE) : 1;

  logic            smp, first, word_end;
  logic [WI_W-1:0] widx;
  logic [LANES-1:0] din;
  logic [WORD_BITS-1:0] lane_word [LANES];

  assign din = {doutb_i, douta_i};

  adc_rx_seq #(
    .WORD_BITS(WORD_BITS), .WORDS_PER_LANE(WORDS_PER_LANE),
    .SCLK_HALF(SCLK_HALF), .CS_SETUP(CS_SETUP), .CS_HOLD(CS_HOLD)
  ) u_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .conv_busy_i(conv_busy_i),
    .cs_n_o(cs_n_o), .sclk_o(sclk_o), .smp_o(smp), .first_o(first),
    .word_end_o(word_end), .widx_o(widx), .active_o(rx_active_o)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    adc_rx_lane #(.WORD_BITS(WORD_BITS)) u_lane (
      .clk(clk), .rst(rst), .smp_i(smp), .word_end_i(word_end),
      .din_i(din[g]), .word_o(lane_word[g])
    );
  end

  assign word_a_o = lane_word[0];
  assign word_b_o = lane_word[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      word_valid_o <= 1'b0;
      chan_a_o     <= '0;
      chan_b_o     <= '0;
      sync_err_o   <= 1'b0;
    end else begin
      word_valid_o <= word_end;
      if (word_end) begin
        chan_a_o <= CHAN_W'(widx);
        chan_b_o <= CHAN_W'(widx) + CHAN_W'(WORDS_PER_LANE);
      end
      if (first) sync_err_o <= ~first_data_i;
    end
  end
endmodule

// File: rtl/adc_dual_serial_rx_chk.sv
module adc_dual_serial_rx_chk #(
  parameter int WORDS_PER_LANE = 4,
  parameter int CHAN_W         = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              conv_busy_i,
  input logic              cs_n_o,
  input logic              sclk_o,
  input logic              word_valid_o,
  input logic [CHAN_W-1:0] chan_a_o,
  input logic [CHAN_W-1:0] chan_b_o,
  input logic              sync_err_o
);
  // R2
  cs_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n_o) |-> !$past(conv_busy_i));
  // R3
  cs_fall_sclk_high_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n_o) |-> sclk_o);
  // R4
  sclk_inside_frame_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sclk_o) |-> (!cs_n_o && !$past(cs_n_o)));
  // R5
  idle_sclk_high_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> sclk_o);
  // R6
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    word_valid_o |=> !word_valid_o);
  // R6
  valid_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    word_valid_o |-> !cs_n_o);
  // R7
  chan_pair_chk: assert property (@(posedge clk) disable iff (rst)
    word_valid_o |-> (chan_a_o < CHAN_W'(WORDS_PER_LANE)) &&
                     (chan_b_o == chan_a_o + CHAN_W'(WORDS_PER_LANE)));
  // R8
  sync_moves_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sync_err_o) |-> !cs_n_o);
endmodule

bind adc_dual_serial_rx adc_dual_serial_rx_chk #(
  .WORDS_PER_LANE(WORDS_PER_LANE), .CHAN_W(CHAN_W)
) u_chk (
  .clk(clk), .rst(rst), .conv_busy_i(conv_busy_i), .cs_n_o(cs_n_o),
  .sclk_o(sclk_o), .word_valid_o(word_valid_o), .chan_a_o(chan_a_o),
  .chan_b_o(chan_b_o), .sync_err_o(sync_err_o)
);

// File: tb/adc_dual_serial_rx_tb.sv
module adc_dual_serial_rx_tb;
  localparam int HALF = 2, SETUP = 2, HOLD = 2;

  logic clk = 0, rst = 1, start = 0, busy = 0;
  logic cs_n, sclk, da, db, fd, wv, serr, act;
  logic [17:0] wa, wb;
  logic [2:0]  ca, cb;

  always #4 clk = ~clk;

  adc_dual_serial_rx #(.SCLK_HALF(HALF), .CS_SETUP(SETUP), .CS_HOLD(HOLD)) u_dut (
    .clk(clk), .rst(rst), .start_i(start), .conv_busy_i(busy),
    .cs_n_o(cs_n), .sclk_o(sclk), .douta_i(da), .doutb_i(db),
    .first_data_i(fd), .word_valid_o(wv), .word_a_o(wa), .chan_a_o(ca),
    .word_b_o(wb), .chan_b_o(cb), .sync_err_o(serr), .rx_active_o(act)
  );

  int n_chk = 0, n_fail = 0;
  task automatic check(input bit ok, input string req, input longint act_v, input longint exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
    end
  endtask

  // converter model: one step per serial clock fall, reset while deselected
  logic [17:0] mv [8];
  bit fd_good = 1;
  int ptr = 0;
  always @(negedge sclk or posedge cs_n)
    if (cs_n) ptr <= 0; else ptr <= ptr + 1;
  always_comb begin
    da = 1'b0; db = 1'b0; fd = 1'b0;
    if (!cs_n && ptr < 72) begin
      da = mv[ptr / 18][17 - (ptr % 18)];
      db = mv[4 + ptr / 18][17 - (ptr % 18)];
      fd = fd_good && (ptr < 18);
    end
  end

  // scoreboard monitor
  logic [41:0] exp_q [$];
  always @(negedge clk) if (!rst && wv) begin
    if (exp_q.size() == 0) check(0, "R9 unexpected word", {ca, wa, cb, wb}, 0);
    else begin
      logic [41:0] e;
      e = exp_q.pop_front();
      check(wa == e[38:21] && wb == e[17:0], "R6 data", {wa, wb}, {e[38:21], e[17:0]});
      check(ca == e[41:39] && cb == e[20:18], "R7 channels", {ca, cb}, {e[41:39], e[20:18]});
    end
  end

  // frame timing monitor
  bit pcs = 1, psc = 1;
  int run = 0, falls = 0;
  always @(negedge clk) begin
    if (rst) begin pcs = 1; psc = 1; run = 0; falls = 0; end
    else begin
      if (pcs && !cs_n) begin
        falls = 0; run = 1;
        check(sclk == 1, "R3 sclk at cs fall", sclk, 1);
      end else if (!cs_n) begin
        if (psc && !sclk) begin
          falls++;
          if (falls == 1) check(run == SETUP, "R3 setup", run, SETUP);
          else check(run == HALF, "R4 high phase", run, HALF);
          run = 1;
        end else if (!psc && sclk) begin
          check(run == HALF, "R4 low phase", run, HALF);
          run = 1;
        end else run++;
      end else if (!pcs && cs_n) begin
        check(falls == 72, "R4 fall count", falls, 72);
        check(run == HALF + HOLD, "R5 hold", run, HALF + HOLD);
      end
      pcs = cs_n; psc = sclk;
    end
  end

  task automatic frame(input bit hold_busy, input bit fd_ok, input bit restart);
    for (int i = 0; i < 4; i++) exp_q.push_back({3'(i), mv[i], 3'(i + 4), mv[i + 4]});
    fd_good = fd_ok;
    busy = hold_busy;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    if (hold_busy) begin
      repeat (40) @(negedge clk);
      check(cs_n == 1, "R2 waits for busy", cs_n, 1);
      check(act == 1, "R2 active while armed", act, 1);
      busy = 0;
    end
    while (cs_n) @(negedge clk);
    if (restart) begin
      repeat (30) @(negedge clk);
      start = 1;
      @(negedge clk) start = 0;
    end
    while (act) @(negedge clk);
    repeat (20) @(negedge clk);
    check(cs_n == 1 && act == 0, "R9 no second frame", {cs_n, act}, 2'b10);
    check(exp_q.size() == 0, "R9 four words delivered", exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [17:0] lfsr;
    lfsr = 18'h2B5C1;
    repeat (4) @(negedge clk);
    check(cs_n == 1 && sclk == 1, "R1 reset lines", {cs_n, sclk}, 2'b11);
    check(wv == 0 && serr == 0 && act == 0, "R1 reset flags", {wv, serr, act}, 0);
    rst = 0;
    @(negedge clk);
    check(cs_n == 1 && sclk == 1 && wv == 0 && act == 0, "R1 after release", {cs_n, sclk, wv, act}, 4'b1100);

    mv[0] = 18'h1FFFF; mv[1] = 18'h20000; mv[2] = 18'h00000; mv[3] = 18'h3FFFF;
    mv[4] = 18'h2AAAA; mv[5] = 18'h15555; mv[6] = 18'h00001; mv[7] = 18'h20001;
    frame(0, 1, 0);
    check(serr == 0, "R8 marker present", serr, 0);

    for (int i = 0; i < 8; i++) begin lfsr = lfsr * 18'd1103 + 18'd12345; mv[i] = lfsr; end
    frame(1, 1, 1);

    for (int i = 0; i < 8; i++) begin lfsr = lfsr * 18'd1103 + 18'd12345; mv[i] = lfsr; end
    frame(0, 0, 0);
    check(serr == 1, "R8 marker missing", serr, 1);

    for (int i = 0; i < 8; i++) mv[i] = 18'(i * 18'h8421);
    frame(0, 1, 0);
    check(serr == 0, "R8 cleared next frame", serr, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule